// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration

This block is a 2048-word by 8-bit memory that two independent agents, called left and right, can read and write on the same clock. Each side has its own active-low select, read/write strobe (low means write), active-low output enable, 11-bit address and 8-bit write and read data. The bidirectional data bus of a discrete part is split into an input, an output and an output-valid flag.

When both selected sides address the same word, an arbiter grants the side that settled on that word first. It pulls the other side's active-low busy flag low and suppresses that side's writes. A mode input selects arbitration (master) or expansion (slave). In slave mode the busy outputs stay high and each side's busy input only gates that side's writes. This lets several memories share the decision of a single master when the data word is widened.

Top module: `dpram_collide`

## Requirements
- R1: A side writes `din` into the word at its address on a rising edge only when its select is low and its read/write is low, and no block applies.
- R2: A side with select low, read/write high and output enable low presents the stored word on `dout` with `doutEn` high after the next rising edge. If select or output enable is high at that edge, `doutEn` is low after it.
- R3: Both busy outputs are high whenever either select is high or the two addresses differ.
- R4: A side arrives in a cycle when its select has just gone low, or when its address has changed while it stays selected. On a match, the side that arrived later sees its busy output low and the earlier side keeps busy high, for as long as the match lasts.
- R5: If both sides arrive in the same cycle on the same word, left wins and only right's busy goes low.
- R6: The two busy outputs are never low together.
- R7: Arbitration ignores read/write. Two reads of the same word also produce a busy flag.
- R8: In master mode a write from the busy side leaves memory unchanged. The busy input pins have no effect in this mode.
- R9: A read on the busy side still completes and returns data after the next edge.
- R10: In slave mode both busy outputs stay high and no arbitration takes place. A low busy input blocks that side's writes, and a high busy input allows them.
- R11: When one side writes a word on the same edge as the other side reads it, the read returns the new data (write-first).
- R12: The busy flag goes high in the same cycle that the match ends. The next match is arbitrated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = arbitrate internally, 0 = busy pins are write-block inputs |
| leftCeN | input | 1 | Left select, active low |
| leftRwN | input | 1 | Left read (1) / write (0) |
| leftOeN | input | 1 | Left output enable, active low |
| leftAddr | input | 11 | Left word address |
| leftDin | input | 8 | Left write data |
| leftDout | output | 8 | Left read data |
| leftDoutEn | output | 1 | Left read data is driven |
| leftBusyInN | input | 1 | Left write block in slave mode, active low |
| leftBusyOutN | output | 1 | Left busy flag in master mode, active low |
| rightCeN | input | 1 | Right select, active low |
| rightRwN | input | 1 | Right read (1) / write (0) |
| rightOeN | input | 1 | Right output enable, active low |
| rightAddr | input | 11 | Right word address |
| rightDin | input | 8 | Right write data |
| rightDout | output | 8 | Right read data |
| rightDoutEn | output | 1 | Right read data is driven |
| rightBusyInN | input | 1 | Right write block in slave mode, active low |
| rightBusyOutN | output | 1 | Right busy flag in master mode, active low |

## Verification
The busy flags are combinational from the current selects and addresses plus the registered winner. The bench drives inputs just after a falling edge and samples busy a nanosecond later, in the same cycle. Read data and its valid flag come from registers loaded at the rising edge, so they are checked at the following falling edge, one cycle after the request is driven. A blocked or granted write becomes visible through a read on the same edge (write-first) or through a read issued in a later cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } winner_e;

  // Per-side strobes from control to datapath; index 0 = left, 1 = right
  typedef struct packed {
    logic [1:0] wr;
    logic [1:0] rd;
  } strobe_t;

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftBusyInN,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output strobe_t           strobes
);

  localparam int SIDES = 2;

  logic [ADDR_W-1:0] addrV    [SIDES];
  logic [ADDR_W-1:0] prevAddr [SIDES];
  logic [SIDES-1:0]  active;
  logic [SIDES-1:0]  wasActive;
  logic [SIDES-1:0]  arrive;
  logic [SIDES-1:0]  rwN;
  logic [SIDES-1:0]  pinBlock;
  logic [SIDES-1:0]  arbBusy;
  logic [SIDES-1:0]  block;

  winner_e winQ;
  winner_e winNow;
  logic    collide;

  assign addrV[0]  = leftAddr;
  assign addrV[1]  = rightAddr;
  assign active    = {~rightCeN, ~leftCeN};
  assign rwN       = {rightRwN, leftRwN};
  assign pinBlock  = {~rightBusyInN, ~leftBusyInN};

  assign collide = active[0] && active[1] && (leftAddr == rightAddr);

  // Per-side arrival tracking
  for (genvar g = 0; g < SIDES; g++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wasActive[g] <= 1'b0;
        prevAddr[g]  <= '0;
      end else begin
        wasActive[g] <= active[g];
        prevAddr[g]  <= addrV[g];
      end
    end

    assign arrive[g] = active[g] && (!wasActive[g] || (addrV[g] != prevAddr[g]));
    assign block[g]  = masterMode ? arbBusy[g] : pinBlock[g];
    assign strobes.wr[g] = active[g] && !rwN[g] && !block[g];
    assign strobes.rd[g] = active[g] && rwN[g];
  end

  // Winner selection: keep a standing decision, else the earlier side wins,
  // a tie goes to the left side
  always_comb begin
    winNow = winQ;
    if (!collide) begin
      winNow = WIN_NONE;
    end else if (winQ == WIN_NONE) begin
      winNow = (arrive[0] && !arrive[1]) ? WIN_RIGHT : WIN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ <= WIN_NONE;
    end else begin
      winQ <= masterMode ? winNow : WIN_NONE;
    end
  end

  assign arbBusy[0] = masterMode && collide && (winNow == WIN_RIGHT);
  assign arbBusy[1] = masterMode && collide && (winNow == WIN_LEFT);

  assign leftBusyOutN  = ~arbBusy[0];
  assign rightBusyOutN = ~arbBusy[1];

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!leftBusyOutN && !rightBusyOutN)); // R6

  AST_IDLE_WHEN_APART: assert property (@(posedge clk) disable iff (!rstN)
    (leftCeN || rightCeN || (leftAddr != rightAddr)) |-> (leftBusyOutN && rightBusyOutN)); // R3

  AST_SLAVE_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftBusyOutN && rightBusyOutN)); // R10

  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && collide && winQ == WIN_NONE && arrive[0] && arrive[1]) |-> (!rightBusyOutN && leftBusyOutN)); // R5

  AST_WINNER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && masterMode && $past(masterMode) && collide && $past(collide)) |->
      ($stable(leftBusyOutN) && $stable(rightBusyOutN))); // R4

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !collide |=> (winQ == WIN_NONE)); // R12

endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftDin,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightDin,
  input  logic              rightOeN,
  output logic [DATA_W-1:0] leftDout,
  output logic              leftDoutEn,
  output logic [DATA_W-1:0] rightDout,
  output logic              rightDoutEn
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SIDES = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrV [SIDES];
  logic [DATA_W-1:0] dinV  [SIDES];
  logic [DATA_W-1:0] doutQ [SIDES];
  logic [SIDES-1:0]  oeN;
  logic [SIDES-1:0]  doutEnQ;

  assign addrV[0] = leftAddr;
  assign addrV[1] = rightAddr;
  assign dinV[0]  = leftDin;
  assign dinV[1]  = rightDin;
  assign oeN      = {rightOeN, leftOeN};

  // Right is applied first so the left side wins a double write (slave mode)
  always_ff @(posedge clk) begin
    for (int s = SIDES - 1; s >= 0; s--) begin
      if (strobes.wr[s]) begin
        mem[addrV[s]] <= dinV[s];
      end
    end
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_read
    localparam int OTHER = 1 - g;
    logic otherHit;

    assign otherHit = strobes.wr[OTHER] && (addrV[OTHER] == addrV[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doutQ[g]   <= '0;
        doutEnQ[g] <= 1'b0;
      end else begin
        doutEnQ[g] <= strobes.rd[g] && !oeN[g];
        if (strobes.rd[g]) begin
          doutQ[g] <= otherHit ? dinV[OTHER] : mem[addrV[g]];
        end
      end
    end
  end

  assign leftDout    = doutQ[0];
  assign leftDoutEn  = doutEnQ[0];
  assign rightDout   = doutQ[1];
  assign rightDoutEn = doutEnQ[1];

  AST_QUIET_MEMORY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wr[0] && !strobes.wr[1]) |=> (mem[$past(leftAddr)] === $past(mem[leftAddr]))); // R8

  AST_WRITE_FIRST_R: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rd[1] && strobes.wr[0] && leftAddr == rightAddr) |=> (rightDout == $past(leftDin))); // R11

  AST_WRITE_FIRST_L: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rd[0] && strobes.wr[1] && leftAddr == rightAddr) |=> (leftDout == $past(rightDin))); // R11

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic              leftRwN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftDin,
  output logic [DATA_W-1:0] leftDout,
  output logic              leftDoutEn,
  input  logic              leftBusyInN,
  output logic              leftBusyOutN,
  input  logic              rightCeN,
  input  logic              rightRwN,
  input  logic              rightOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightDin,
  output logic [DATA_W-1:0] rightDout,
  output logic              rightDoutEn,
  input  logic              rightBusyInN,
  output logic              rightBusyOutN
);

  strobe_t strobes;

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk          (clk),
    .rstN         (rstN),
    .masterMode   (masterMode),
    .leftCeN      (leftCeN),
    .leftRwN      (leftRwN),
    .leftAddr     (leftAddr),
    .leftBusyInN  (leftBusyInN),
    .rightCeN     (rightCeN),
    .rightRwN     (rightRwN),
    .rightAddr    (rightAddr),
    .rightBusyInN (rightBusyInN),
    .leftBusyOutN (leftBusyOutN),
    .rightBusyOutN(rightBusyOutN),
    .strobes      (strobes)
  );

  dpram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .leftAddr   (leftAddr),
    .leftDin    (leftDin),
    .leftOeN    (leftOeN),
    .rightAddr  (rightAddr),
    .rightDin   (rightDin),
    .rightOeN   (rightOeN),
    .leftDout   (leftDout),
    .leftDoutEn (leftDoutEn),
    .rightDout  (rightDout),
    .rightDoutEn(rightDoutEn)
  );

endmodule

// File: tb/sim_dpram_collide.sv
`timescale 1ns/1ps
module sim_dpram_collide;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterMode = 1'b1;
  logic        leftCeN = 1'b1, leftRwN = 1'b1, leftOeN = 1'b1;
  logic [10:0] leftAddr = '0;
  logic [7:0]  leftDin = '0;
  logic [7:0]  leftDout;
  logic        leftDoutEn;
  logic        leftBusyInN = 1'b1;
  logic        leftBusyOutN;
  logic        rightCeN = 1'b1, rightRwN = 1'b1, rightOeN = 1'b1;
  logic [10:0] rightAddr = '0;
  logic [7:0]  rightDin = '0;
  logic [7:0]  rightDout;
  logic        rightDoutEn;
  logic        rightBusyInN = 1'b1;
  logic        rightBusyOutN;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dpram_collide u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftCeN(leftCeN), .leftRwN(leftRwN), .leftOeN(leftOeN), .leftAddr(leftAddr),
    .leftDin(leftDin), .leftDout(leftDout), .leftDoutEn(leftDoutEn),
    .leftBusyInN(leftBusyInN), .leftBusyOutN(leftBusyOutN),
    .rightCeN(rightCeN), .rightRwN(rightRwN), .rightOeN(rightOeN), .rightAddr(rightAddr),
    .rightDin(rightDin), .rightDout(rightDout), .rightDoutEn(rightDoutEn),
    .rightBusyInN(rightBusyInN), .rightBusyOutN(rightBusyOutN)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBusy(string req, logic expL, logic expR);
    #1;
    chk({req, " left busy"}, {7'd0, leftBusyOutN}, {7'd0, expL});
    chk({req, " right busy"}, {7'd0, rightBusyOutN}, {7'd0, expR});
    chk("R6 exclusive busy", {7'd0, (!leftBusyOutN && !rightBusyOutN)}, 8'd0);
  endtask

  task automatic setL(logic ce, logic rw, logic oe, logic [10:0] a, logic [7:0] d);
    leftCeN = ce; leftRwN = rw; leftOeN = oe; leftAddr = a; leftDin = d;
  endtask

  task automatic setR(logic ce, logic rw, logic oe, logic [10:0] a, logic [7:0] d);
    rightCeN = ce; rightRwN = rw; rightOeN = oe; rightAddr = a; rightDin = d;
  endtask

  task automatic idle();
    @(negedge clk);
    setL(1, 1, 1, 11'h000, 8'h00);
    setR(1, 1, 1, 11'h000, 8'h00);
  endtask

  task automatic t_reset();
    #1;
    chk("R3 reset left busy", {7'd0, leftBusyOutN}, 8'd1);
    chk("R3 reset right busy", {7'd0, rightBusyOutN}, 8'd1);
    chk("R2 reset left en", {7'd0, leftDoutEn}, 8'd0);
    chk("R2 reset right en", {7'd0, rightDoutEn}, 8'd0);
  endtask

  task automatic t_basic();
    idle();
    @(negedge clk);
    setL(0, 0, 1, 11'h005, 8'hA5);
    setR(0, 0, 1, 11'h7FF, 8'h3C);
    @(negedge clk);
    setL(0, 0, 1, 11'h100, 8'h11);
    setR(1, 1, 1, 11'h000, 8'h00);
    @(negedge clk);
    setL(0, 1, 0, 11'h7FF, 8'h00);
    setR(0, 1, 0, 11'h005, 8'h00);
    @(negedge clk);
    chk("R1 left reads right's write", leftDout, 8'h3C);
    chk("R2 left en", {7'd0, leftDoutEn}, 8'd1);
    chk("R1 right reads left's write", rightDout, 8'hA5);
    setL(0, 1, 1, 11'h7FF, 8'h00);
    setR(1, 1, 0, 11'h005, 8'h00);
    @(negedge clk);
    chk("R2 left oe high en", {7'd0, leftDoutEn}, 8'd0);
    chk("R2 right ce high en", {7'd0, rightDoutEn}, 8'd0);
  endtask

  task automatic t_no_match();
    idle();
    @(negedge clk);
    setL(0, 1, 0, 11'h010, 8'h00);
    setR(0, 1, 0, 11'h011, 8'h00);
    chkBusy("R3 differing addresses", 1, 1);
    @(negedge clk);
    setR(1, 1, 0, 11'h010, 8'h00);
    chkBusy("R3 right deselected", 1, 1);
  endtask

  task automatic t_later_loses();
    idle();
    @(negedge clk);
    setL(0, 1, 0, 11'h100, 8'h00);
    chkBusy("R4 left alone", 1, 1);
    @(negedge clk);
    setR(0, 0, 1, 11'h100, 8'h77);
    chkBusy("R4 right arrives later", 1, 0);
    @(negedge clk);
    chk("R8 right write blocked", leftDout, 8'h11);
    chkBusy("R4 right still busy", 1, 0);
    idle();
    @(negedge clk);
    setR(0, 1, 0, 11'h100, 8'h00);
    @(negedge clk);
    setL(0, 0, 1, 11'h100, 8'h66);
    chkBusy("R4 left arrives later", 0, 1);
    @(negedge clk);
    chk("R8 left write blocked", rightDout, 8'h11);
  endtask

  task automatic t_tie_release();
    idle();
    @(negedge clk);
    setL(0, 1, 0, 11'h300, 8'h00);
    setR(0, 1, 0, 11'h300, 8'h00);
    chkBusy("R5 R7 tie of two reads", 1, 0);
    @(negedge clk);
    chkBusy("R5 tie held", 1, 0);
    @(negedge clk);
    chk("R9 busy read completes", {7'd0, rightDoutEn}, 8'd1);
    setR(0, 1, 0, 11'h301, 8'h00);
    chkBusy("R12 release on mismatch", 1, 1);
    @(negedge clk);
    setR(0, 1, 0, 11'h300, 8'h00);
    chkBusy("R12 rematch arbitrated afresh", 1, 0);
    @(negedge clk);
    setL(1, 1, 0, 11'h300, 8'h00);
    chkBusy("R12 release on deselect", 1, 1);
  endtask

  task automatic t_write_first();
    idle();
    @(negedge clk);
    setL(0, 0, 1, 11'h200, 8'h9A);
    @(negedge clk);
    setL(0, 0, 1, 11'h200, 8'h5B);
    setR(0, 1, 0, 11'h200, 8'h00);
    chkBusy("R4 reader arrives later", 1, 0);
    @(negedge clk);
    chk("R11 R9 busy read sees new write", rightDout, 8'h5B);
    chk("R9 busy read valid", {7'd0, rightDoutEn}, 8'd1);
    setL(0, 1, 0, 11'h200, 8'h00);
    setR(1, 1, 1, 11'h000, 8'h00);
    @(negedge clk);
    chk("R11 word holds new data", leftDout, 8'h5B);
  endtask

  task automatic t_pin_ignored();
    idle();
    leftBusyInN = 1'b0;
    rightBusyInN = 1'b0;
    @(negedge clk);
    setL(0, 0, 1, 11'h400, 8'hC3);
    chkBusy("R8 master drives own busy", 1, 1);
    @(negedge clk);
    setL(0, 1, 0, 11'h400, 8'h00);
    @(negedge clk);
    chk("R8 busy pin ignored in master", leftDout, 8'hC3);
    leftBusyInN = 1'b1;
    rightBusyInN = 1'b1;
  endtask

  task automatic t_slave();
    idle();
    masterMode = 1'b0;
    @(negedge clk);
    setL(0, 1, 0, 11'h500, 8'h00);
    setR(0, 1, 0, 11'h500, 8'h00);
    chkBusy("R10 slave no arbitration", 1, 1);
    @(negedge clk);
    setR(1, 1, 1, 11'h000, 8'h00);
    setL(0, 0, 1, 11'h500, 8'h21);
    @(negedge clk);
    leftBusyInN = 1'b0;
    setL(0, 0, 1, 11'h500, 8'h99);
    @(negedge clk);
    leftBusyInN = 1'b1;
    setL(0, 1, 0, 11'h500, 8'h00);
    @(negedge clk);
    chk("R10 low busy input blocks write", leftDout, 8'h21);
    setR(0, 0, 1, 11'h500, 8'h44);
    @(negedge clk);
    chk("R10 high busy input allows write", leftDout, 8'h44);
    idle();
    masterMode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_basic();
    t_no_match();
    t_later_loses();
    t_tie_release();
    t_write_first();
    t_pin_ignored();
    t_slave();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule